// File: doc/BRIEF.md
# Prefetch pollution monitor

This block sits beside a set-associative cache that holds both demand lines and prefetched lines, and keeps a shadow table of victim tags for every cache set. Whenever a prefetch pushes a demand line out of the cache, the monitor records that line's tag. At any moment the demand lines in the cache together with the recorded victim tags describe the cache as it would look had no prefetching taken place. Each table set has one entry per cache way. Entries are kept in least-recently-used order and are not tied to any particular prefetch line.

The cache controller reports two kinds of event over one valid/ready port, at most one per cycle. A fill event names the set, the victim tag, whether the incoming line is a prefetch, whether the victim way held a valid line, and whether that victim was a prefetch. A lookup event names the set and the requested tag, whether the cache hit, and whether the line that hit is still marked as a prefetch. From these events the monitor derives three figures. Useful prefetches are those later hit, less those whose hits were paid for by a lost demand line. Harmful prefetches are those whose displaced demand tags were asked for again. Unused prefetches are those filled but never hit. Every lookup is answered one cycle later with a flag saying whether its tag matched a recorded victim.

Top module: `pollution_monitor`

## Requirements
- R1: While `rst_n` is low, all counters read 0, `rsp_valid` is 0 and `evt_ready` is 0. `evt_ready` rises within three rising clock edges after reset is released.
- R2: A prefetch fill into an invalid way (`fill_pf`=1, `victim_valid`=0) adds a placeholder entry that takes part in LRU order but never matches any lookup tag.
- R3: A prefetch fill that evicts a valid demand line (`victim_valid`=1, `victim_pf`=0) records `evt_tag` as the most recently used entry of that set.
- R4: A prefetch fill that replaces another prefetch line (`victim_valid`=1, `victim_pf`=1) leaves the table unchanged.
- R5: A demand fill (`fill_pf`=0) that replaces a prefetch line removes the least recently used entry of that set.
- R6: A demand fill that replaces a valid demand line in a set with at least one entry drops that set's least recently used entry and records `evt_tag` as most recently used. In a set with no entries the same fill changes nothing.
- R7: A lookup that misses the cache (`cache_hit`=0) but matches a recorded tag adds one harmful prefetch. The matching entry is kept and becomes the set's least recently used entry.
- R8: A lookup that hits a prefetch line (`cache_hit`=1, `hit_pf`=1) counts one prefetch hit. If the tag does not match the table, the set's least recently used entry is removed. If it does match, that entry is removed and one harmful prefetch is also counted.
- R9: Every accepted lookup gives `rsp_valid`=1 on the following cycle. `rsp_hit` is then 1 exactly when a valid, non-placeholder entry of the addressed set held the lookup tag. In every other cycle `rsp_valid` is 0.
- R10: A lookup that hits a demand line and matches a recorded tag adds one harmful prefetch and makes that entry least recently used. A demand hit with no match changes nothing.
- R11: The counters update one cycle after the event. `bad_cnt` equals the number of table matches. `ugly_cnt` equals the prefetch fills minus the prefetch hits, floored at 0. `good_cnt` equals the prefetch hits minus the table matches, floored at 0.
- R12: Each raw tally (prefetch fills, prefetch hits, table matches) stops at 2^CNT_W−1 instead of wrapping. The outputs are derived from the stopped values.
- R13: An event is taken only in a cycle where both `evt_valid` and `evt_ready` are 1. Otherwise the inputs have no effect on the table, the counters or the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken this cycle |
| evt_lookup | input | 1 | 1 = lookup event, 0 = fill event |
| evt_set | input | $clog2(SETS) | Cache set index |
| evt_tag | input | TAG_W | Victim tag (fill) or requested tag (lookup) |
| fill_pf | input | 1 | Fill brings a prefetched line |
| victim_valid | input | 1 | Fill way held a valid line |
| victim_pf | input | 1 | Fill victim was a prefetched line |
| cache_hit | input | 1 | Lookup hit in the cache |
| hit_pf | input | 1 | Lookup hit a line still marked prefetched |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup tag matched a recorded victim |
| good_cnt | output | CNT_W | Useful prefetches |
| bad_cnt | output | CNT_W | Harmful prefetches |
| ugly_cnt | output | CNT_W | Unused prefetches |

## Verification
The bench targets the LRU choices. Marking a matched entry as oldest instead of freeing it is checked by a later removal that must take that entry. A design that freed the entry at once, or moved it to the wrong end, would leave the wrong tag behind. Placeholder entries are probed with tag 0, so a design that compared their stored tag would report false matches. A prefetch-over-prefetch fill, and a demand-over-demand fill into an empty set, are each followed by probes that expose any stray insertion. A narrow-counter copy shows whether the tallies stop at their maximum or wrap.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_INS_NULL = 3'd1,
    OP_INS_TAG  = 3'd2,
    OP_DROP_LRU = 3'd3,
    OP_SWAP_LRU = 3'd4,
    OP_AGE_OUT  = 3'd5,
    OP_DROP_WAY = 3'd6
  } tbl_op_e;
endpackage

// File: rtl/pm_set_view.sv
module pm_set_view #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int AW = $clog2(WAYS),
  localparam int CW = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            nul,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][AW-1:0]    ages,
  input  logic [TAG_W-1:0]           probe,
  output logic                       hit,
  output logic [AW-1:0]              hit_way,
  output logic                       free_ok,
  output logic [AW-1:0]              free_way,
  output logic [AW-1:0]              lru_way,
  output logic [CW-1:0]              occ
);
  // lowest index wins for match and free slot
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    free_ok  = 1'b0;
    free_way = '0;
    occ      = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[w]) occ = occ + CW'(1);
      if (vld[w] && !nul[w] && tags[w] == probe) begin
        hit     = 1'b1;
        hit_way = AW'(w);
      end
      if (!vld[w]) begin
        free_ok  = 1'b1;
        free_way = AW'(w);
      end
    end
  end

  // valid ages are distinct 0..occ-1; the oldest holds occ-1
  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[w] && CW'(ages[w]) == occ - CW'(1)) lru_way = AW'(w);
    end
  end
endmodule

// File: rtl/pm_set_update.sv
module pm_set_update
  import pm_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int AW = $clog2(WAYS),
  localparam int CW = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            nul,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][AW-1:0]    ages,
  input  tbl_op_e                    op,
  input  logic [AW-1:0]              sel_way,
  input  logic [AW-1:0]              lru_way,
  input  logic [AW-1:0]              free_way,
  input  logic [CW-1:0]              occ,
  input  logic [TAG_W-1:0]           new_tag,
  output logic [WAYS-1:0]            vld_n,
  output logic [WAYS-1:0]            nul_n,
  output logic [WAYS-1:0][TAG_W-1:0] tags_n,
  output logic [WAYS-1:0][AW-1:0]    ages_n
);
  logic [AW-1:0] pivot;
  assign pivot = ages[sel_way];

  always_comb begin
    vld_n  = vld;
    nul_n  = nul;
    tags_n = tags;
    ages_n = ages;
    unique case (op)
      OP_INS_NULL, OP_INS_TAG: begin
        for (int w = 0; w < WAYS; w++)
          if (vld[w]) ages_n[w] = ages[w] + AW'(1);
        vld_n[free_way]  = 1'b1;
        nul_n[free_way]  = (op == OP_INS_NULL);
        tags_n[free_way] = (op == OP_INS_TAG) ? new_tag : '0;
        ages_n[free_way] = '0;
      end
      OP_DROP_LRU: vld_n[lru_way] = 1'b0;
      OP_SWAP_LRU: begin
        for (int w = 0; w < WAYS; w++)
          if (vld[w] && AW'(w) != lru_way) ages_n[w] = ages[w] + AW'(1);
        nul_n[lru_way]  = 1'b0;
        tags_n[lru_way] = new_tag;
        ages_n[lru_way] = '0;
      end
      OP_AGE_OUT: begin
        for (int w = 0; w < WAYS; w++)
          if (vld[w] && ages[w] > pivot) ages_n[w] = ages[w] - AW'(1);
        ages_n[sel_way] = AW'(occ - CW'(1));
      end
      OP_DROP_WAY: begin
        for (int w = 0; w < WAYS; w++)
          if (vld[w] && ages[w] > pivot) ages_n[w] = ages[w] - AW'(1);
        vld_n[sel_way] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pm_tally.sv
module pm_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inc_pf,
  input  logic             inc_pfh,
  input  logic             inc_evh,
  output logic [CNT_W-1:0] good,
  output logic [CNT_W-1:0] bad,
  output logic [CNT_W-1:0] ugly
);
  logic [CNT_W-1:0] pf_q, pfh_q, evh_q;
  logic [CNT_W-1:0] pf_d, pfh_d, evh_d;

  always_comb begin
    pf_d  = (inc_pf  && pf_q  != '1) ? pf_q  + CNT_W'(1) : pf_q;
    pfh_d = (inc_pfh && pfh_q != '1) ? pfh_q + CNT_W'(1) : pfh_q;
    evh_d = (inc_evh && evh_q != '1) ? evh_q + CNT_W'(1) : evh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q  <= '0;
      pfh_q <= '0;
      evh_q <= '0;
    end else if (en) begin
      pf_q  <= pf_d;
      pfh_q <= pfh_d;
      evh_q <= evh_d;
    end
  end

  assign bad  = evh_q;
  assign good = (pfh_q > evh_q) ? pfh_q - evh_q : '0;
  assign ugly = (pf_q > pfh_q) ? pf_q - pfh_q : '0;
endmodule

// File: rtl/pollution_monitor.sv
module pollution_monitor
  import pm_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16,
  localparam int SW = $clog2(SETS),
  localparam int AW = $clog2(WAYS),
  localparam int CW = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic             evt_lookup,
  input  logic [SW-1:0]    evt_set,
  input  logic [TAG_W-1:0] evt_tag,
  input  logic             fill_pf,
  input  logic             victim_valid,
  input  logic             victim_pf,
  input  logic             cache_hit,
  input  logic             hit_pf,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt,
  output logic [CNT_W-1:0] ugly_cnt
);
  // reset release synchroniser gating the event port
  logic [1:0] rsync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign evt_ready = rsync_q[1];

  logic acc;
  assign acc = evt_valid && evt_ready;

  // table storage
  logic [SETS-1:0][WAYS-1:0]            vld_q, nul_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][AW-1:0]    age_q;

  logic [WAYS-1:0]            cur_vld, cur_nul, nxt_vld, nxt_nul;
  logic [WAYS-1:0][TAG_W-1:0] cur_tag, nxt_tag;
  logic [WAYS-1:0][AW-1:0]    cur_age, nxt_age;

  assign cur_vld = vld_q[evt_set];
  assign cur_nul = nul_q[evt_set];
  assign cur_tag = tag_q[evt_set];
  assign cur_age = age_q[evt_set];

  logic          probe_hit, free_ok;
  logic [AW-1:0] hit_way, free_way, lru_way;
  logic [CW-1:0] occ;

  pm_set_view #(.WAYS(WAYS), .TAG_W(TAG_W)) u_view (
    .vld(cur_vld), .nul(cur_nul), .tags(cur_tag), .ages(cur_age),
    .probe(evt_tag), .hit(probe_hit), .hit_way(hit_way),
    .free_ok(free_ok), .free_way(free_way), .lru_way(lru_way), .occ(occ)
  );

  // event decode
  tbl_op_e op;
  logic    inc_pf, inc_pfh, inc_evh;

  always_comb begin
    op      = OP_NONE;
    inc_pf  = 1'b0;
    inc_pfh = 1'b0;
    inc_evh = 1'b0;
    if (!evt_lookup) begin
      if (fill_pf) begin
        inc_pf = 1'b1;
        if (!victim_valid && free_ok)         op = OP_INS_NULL;
        else if (victim_valid && !victim_pf && free_ok) op = OP_INS_TAG;
      end else if (victim_valid) begin
        if (victim_pf)        op = OP_DROP_LRU;
        else if (occ != '0)   op = OP_SWAP_LRU;
      end
    end else begin
      if (cache_hit && hit_pf) begin
        inc_pfh = 1'b1;
        inc_evh = probe_hit;
        op      = probe_hit ? OP_DROP_WAY : OP_DROP_LRU;
      end else if (probe_hit) begin
        inc_evh = 1'b1;
        op      = OP_AGE_OUT;
      end
    end
  end

  pm_set_update #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd (
    .vld(cur_vld), .nul(cur_nul), .tags(cur_tag), .ages(cur_age),
    .op(op), .sel_way(hit_way), .lru_way(lru_way), .free_way(free_way),
    .occ(occ), .new_tag(evt_tag),
    .vld_n(nxt_vld), .nul_n(nxt_nul), .tags_n(nxt_tag), .ages_n(nxt_age)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        nul_q[s] <= '0;
        tag_q[s] <= '0;
        age_q[s] <= '0;
      end
    end else if (acc) begin
      vld_q[evt_set] <= nxt_vld;
      nul_q[evt_set] <= nxt_nul;
      tag_q[evt_set] <= nxt_tag;
      age_q[evt_set] <= nxt_age;
    end
  end

  // lookup answer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= acc && evt_lookup;
      rsp_hit   <= acc && evt_lookup && probe_hit;
    end
  end

  pm_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .en(acc),
    .inc_pf(inc_pf), .inc_pfh(inc_pfh), .inc_evh(inc_evh),
    .good(good_cnt), .bad(bad_cnt), .ugly(ugly_cnt)
  );
endmodule

// File: rtl/pm_monitor_chk.sv
module pm_monitor_chk #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int CNT_W = 16,
  localparam int SW = $clog2(SETS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       evt_valid,
  input logic                       evt_ready,
  input logic                       evt_lookup,
  input logic [SW-1:0]              evt_set,
  input logic                       fill_pf,
  input logic                       victim_valid,
  input logic                       victim_pf,
  input logic                       rsp_valid,
  input logic [CNT_W-1:0]           bad_cnt,
  input logic [CNT_W-1:0]           ugly_cnt,
  input logic [SETS-1:0][WAYS-1:0]  vld_q
);
  logic acc;
  assign acc = evt_valid && evt_ready;

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && evt_lookup) |=> rsp_valid);

  assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && evt_lookup) |=> !rsp_valid);

  assert_null_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !evt_lookup && fill_pf && !victim_valid && $countones(vld_q[evt_set]) < WAYS)
    |=> $countones(vld_q[$past(evt_set)]) == $past($countones(vld_q[evt_set])) + 1);

  assert_pf_over_pf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !evt_lookup && fill_pf && victim_valid && victim_pf)
    |=> vld_q[$past(evt_set)] == $past(vld_q[evt_set]));

  assert_bad_never_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bad_cnt >= $past(bad_cnt));

  assert_fill_keeps_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !evt_lookup) |=> $stable(bad_cnt));

  assert_idle_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(bad_cnt) && $stable(ugly_cnt) && $stable(vld_q)));
endmodule

bind pollution_monitor pm_monitor_chk #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_lookup(evt_lookup), .evt_set(evt_set), .fill_pf(fill_pf),
  .victim_valid(victim_valid), .victim_pf(victim_pf), .rsp_valid(rsp_valid),
  .bad_cnt(bad_cnt), .ugly_cnt(ugly_cnt), .vld_q(vld_q)
);

// File: tb/sim_pollution_monitor.sv
`timescale 1ns/1ps
module sim_pollution_monitor;
  localparam int SETS = 8, WAYS = 4, TAG_W = 12, CNT_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, evt_valid, evt_lookup, fill_pf, victim_valid, victim_pf, cache_hit, hit_pf;
  logic [2:0] evt_set;
  logic [TAG_W-1:0] evt_tag;
  logic evt_ready, rsp_valid, rsp_hit;
  logic [CNT_W-1:0] good_cnt, bad_cnt, ugly_cnt;
  logic r1_ready, r1_valid, r1_hit;
  logic [1:0] g1, b1, u1c;

  pollution_monitor #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_lookup(evt_lookup), .evt_set(evt_set), .evt_tag(evt_tag), .fill_pf(fill_pf),
    .victim_valid(victim_valid), .victim_pf(victim_pf), .cache_hit(cache_hit),
    .hit_pf(hit_pf), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt), .ugly_cnt(ugly_cnt));

  pollution_monitor #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(2)) u1 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(r1_ready),
    .evt_lookup(evt_lookup), .evt_set(evt_set), .evt_tag(evt_tag), .fill_pf(fill_pf),
    .victim_valid(victim_valid), .victim_pf(victim_pf), .cache_hit(cache_hit),
    .hit_pf(hit_pf), .rsp_valid(r1_valid), .rsp_hit(r1_hit),
    .good_cnt(g1), .bad_cnt(b1), .ugly_cnt(u1c));

  int checks = 0, errors = 0;
  int e_pf = 0, e_pfh = 0, e_evh = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(string req);
    chk({req, " good"}, int'(good_cnt), (e_pfh > e_evh) ? e_pfh - e_evh : 0);
    chk({req, " bad"},  int'(bad_cnt),  e_evh);
    chk({req, " ugly"}, int'(ugly_cnt), (e_pf > e_pfh) ? e_pf - e_pfh : 0);
  endtask

  task automatic fill(int s, int tag, bit pf, bit vv, bit vpf);
    @(negedge clk);
    evt_valid = 1'b1; evt_lookup = 1'b0; evt_set = 3'(s); evt_tag = TAG_W'(tag);
    fill_pf = pf; victim_valid = vv; victim_pf = vpf; cache_hit = 1'b0; hit_pf = 1'b0;
    @(negedge clk);
    evt_valid = 1'b0;
    if (pf) e_pf++;
    chk("R9 no answer after fill", int'(rsp_valid), 0);
  endtask

  task automatic look(int s, int tag, bit ch, bit hpf, bit exp_hit, string req);
    @(negedge clk);
    evt_valid = 1'b1; evt_lookup = 1'b1; evt_set = 3'(s); evt_tag = TAG_W'(tag);
    fill_pf = 1'b0; victim_valid = 1'b0; victim_pf = 1'b0; cache_hit = ch; hit_pf = hpf;
    @(negedge clk);
    evt_valid = 1'b0;
    if (exp_hit) e_evh++;
    if (ch && hpf) e_pfh++;
    chk({req, " R9 rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " rsp_hit"}, int'(rsp_hit), int'(exp_hit));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; evt_valid = 1'b1; evt_lookup = 1'b0; evt_set = '0; evt_tag = '0;
    fill_pf = 1'b1; victim_valid = 1'b0; victim_pf = 1'b0; cache_hit = 1'b0; hit_pf = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(evt_ready), 0);
    chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1 bad in reset", int'(bad_cnt), 0);
    chk("R1 ugly in reset", int'(ugly_cnt), 0);
    chk("R1 good in reset", int'(good_cnt), 0);
    evt_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready after release", int'(evt_ready), 1);
  endtask

  task automatic t_good_hit;
    fill(7, 'h701, 1, 1, 0);
    fill(7, 'h702, 1, 1, 0);
    look(7, 'h7FF, 1, 1, 0, "R8 pf hit no match");
    chk_cnt("R8 good after pf hit");
    look(7, 'h701, 0, 0, 0, "R8 oldest removed");
    look(7, 'h702, 0, 0, 1, "R8 newer kept");
    chk_cnt("R11 after set 7");
  endtask

  task automatic t_null_and_tag;
    fill(1, 'h000, 1, 0, 0);
    fill(1, 'h0A1, 1, 1, 0);
    look(1, 'h000, 0, 0, 0, "R2 placeholder never matches");
    look(1, 'h0A1, 0, 0, 1, "R3 victim tag recorded");
    look(1, 'h0B2, 0, 0, 0, "R3 foreign tag");
    chk_cnt("R7 harmful counted");
  endtask

  task automatic t_pf_over_pf;
    fill(2, 'h111, 1, 1, 0);
    fill(2, 'h222, 1, 1, 1);
    look(2, 'h222, 0, 0, 0, "R4 no insert");
    look(2, 'h111, 0, 0, 1, "R4 earlier kept");
    chk_cnt("R11 ugly grows by pf fills");
  endtask

  task automatic t_demand_over_pf;
    fill(3, 'h301, 1, 1, 0);
    fill(3, 'h302, 1, 1, 0);
    fill(3, 'h3AA, 0, 1, 1);
    look(3, 'h301, 0, 0, 0, "R5 oldest dropped");
    look(3, 'h302, 0, 0, 1, "R5 newer kept");
  endtask

  task automatic t_demand_over_demand;
    fill(4, 'h401, 1, 1, 0);
    fill(4, 'h402, 1, 1, 0);
    fill(4, 'h403, 0, 1, 0);
    look(4, 'h401, 0, 0, 0, "R6 oldest replaced");
    look(4, 'h403, 0, 0, 1, "R6 victim recorded");
    look(4, 'h402, 0, 0, 1, "R6 other kept");
    fill(5, 'h501, 0, 1, 0);
    look(5, 'h501, 0, 0, 0, "R6 empty set unchanged");
  endtask

  task automatic t_set_lru;
    fill(6, 'h601, 1, 1, 0);
    fill(6, 'h602, 1, 1, 0);
    look(6, 'h602, 0, 0, 1, "R7 miss matches");
    chk_cnt("R7 bad after miss");
    fill(6, 'h6AA, 0, 1, 1);
    look(6, 'h601, 0, 0, 1, "R7 older kept");
    look(6, 'h602, 0, 0, 0, "R7 matched entry made oldest");
  endtask

  task automatic t_pf_hit_match;
    fill(0, 'h001, 1, 1, 0);
    fill(0, 'h002, 1, 1, 0);
    fill(0, 'h003, 1, 1, 0);
    look(0, 'h002, 1, 1, 1, "R8 pf hit with match");
    chk_cnt("R8 counts after pf hit with match");
    look(0, 'h003, 1, 0, 1, "R10 demand hit match");
    fill(0, 'h0AA, 0, 1, 1);
    look(0, 'h003, 0, 0, 0, "R10 entry made oldest");
    look(0, 'h001, 0, 0, 1, "R10 other kept");
    look(0, 'h002, 0, 0, 0, "R8 matched entry removed");
    chk_cnt("R11 after set 0");
  endtask

  task automatic t_ignore;
    @(negedge clk);
    evt_valid = 1'b0; evt_lookup = 1'b0; evt_set = 3'd2; evt_tag = 'h111;
    fill_pf = 1'b0; victim_valid = 1'b1; victim_pf = 1'b0;
    repeat (2) @(negedge clk);
    evt_lookup = 1'b1; cache_hit = 1'b1; hit_pf = 1'b1;
    @(negedge clk);
    chk("R13 no answer without valid", int'(rsp_valid), 0);
    chk_cnt("R13 counters untouched");
    look(2, 'h111, 0, 0, 1, "R13 table untouched");
  endtask

  task automatic t_saturate;
    int sp, sh;
    for (int i = 0; i < 4; i++) fill(5, 'h5F0 + i, 1, 0, 0);
    sp = (e_pf > 3) ? 3 : e_pf;
    sh = (e_pfh > 3) ? 3 : e_pfh;
    chk("R12 bad stops", int'(b1), (e_evh > 3) ? 3 : e_evh);
    chk("R12 ugly from stopped tallies", int'(u1c), (sp > sh) ? sp - sh : 0);
    chk("R12 good from stopped tallies", int'(g1), (sh > ((e_evh > 3) ? 3 : e_evh)) ?
        sh - ((e_evh > 3) ? 3 : e_evh) : 0);
    chk_cnt("R11 wide counters keep counting");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_good_hit();
    t_null_and_tag();
    t_pf_over_pf();
    t_demand_over_pf();
    t_demand_over_demand();
    t_set_lru();
    t_pf_hit_match();
    t_ignore();
    t_saturate();
    finish_run();
  end
endmodule